// File: doc/BRIEF.md
# Split Multiplier Front End

This block sits at the entry of a multiply-accumulate slice. It receives four operands. Two of them, A and B, feed the multipliers. The other two, C and D, are passed on to a downstream adder stage. Each operand can be captured in an input register or passed straight through, and each input register has its own hold control. From A and B the block forms three products: an 8x8 product of the upper bytes, an 8x8 product of the lower bytes, and a full-width product of both operands. Each product can be given its own pipeline register, and the full-width path can have two stages.

Every option is fixed by a parameter. The parameters set which registers exist, whether A and B are read as signed, which clock edge is active, and a half-width-only mode that removes the wide multiplier and ties its result to zero.

The resets are split by half. The upper reset clears A, C and the upper-byte product register. The lower reset clears B, D, the lower-byte product register and both stages of the full-width path. A single clock enable gates every register.

Top module: `msf_top`

## Requirements
- R1: With reset low, clock enable high and hold low, a present input register takes its operand on the active edge. C and D registers drive `c_out`/`d_out` one edge after capture.
- R2: While its hold input is 1 (and its reset is low), an input register keeps its value across edges.
- R3: While `clk_en` is 0 and the resets are low, no register in the block changes.
- R4: A synchronous `rst_hi` clears A, C and the upper product register. A synchronous `rst_lo` clears B, D, the lower product register and both full-width stages.
- R5: Reset wins over hold and over `clk_en` = 0.
- R6: `prod_hi` is A[15:8]·B[15:8] and `prod_lo` is A[7:0]·B[7:0], each 16 bits. An upper byte is two's complement when its operand is marked signed. Lower bytes are always unsigned.
- R7: `prod_full` is the 32-bit product of A and B under each operand's signedness.
- R8: Each present product stage adds exactly one active edge of latency between the registered operands and the product output.
- R9: In half-width-only mode, `prod_full` is constantly zero.
- R10: With the falling edge selected, registers capture on the falling edge of `clk`.
- R11: A register configured absent passes its input to the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clk_en | input | 1 | Enable for every register |
| rst_hi | input | 1 | Synchronous reset, upper half |
| rst_lo | input | 1 | Synchronous reset, lower half and full-width path |
| hold_a | input | 1 | 1 keeps the A register |
| hold_b | input | 1 | 1 keeps the B register |
| hold_c | input | 1 | 1 keeps the C register |
| hold_d | input | 1 | 1 keeps the D register |
| a_in | input | W | Multiplier operand A |
| b_in | input | W | Multiplier operand B |
| c_in | input | W | Pass operand C |
| d_in | input | W | Pass operand D |
| c_out | output | W | Registered or bypassed C |
| d_out | output | W | Registered or bypassed D |
| prod_hi | output | W | Upper-byte product |
| prod_lo | output | W | Lower-byte product |
| prod_full | output | 2W | Full-width product |

## Verification
A reset can coincide with a hold or with a low clock enable on the same edge. The bench provokes this by driving random resets while the holds and `clk_en` are also random. The behavioural model then expects the cleared value, so any design that lets hold or enable block the reset differs from the model on the next compare. A second collision comes from splitting the resets. One half can be cleared while the full-width pipeline is still carrying an operand from the other half. This is judged by checking every output on every cycle, not only after quiet periods.

// File: rtl/msf_pkg.sv
package msf_pkg;
   // half of an operand width, used for the split products
   function automatic int half_of(input int w);
      return w / 2;
   endfunction
endpackage

// File: rtl/msf_reg.sv
module msf_reg #(
   parameter int W       = 16,
   parameter bit PRESENT = 1'b1,
   parameter bit FALL    = 1'b0
) (
   input  logic         clk,
   input  logic         en,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (!PRESENT) begin : g_thru
         assign q = d;
      end else if (FALL) begin : g_neg
         logic [W-1:0] r;
         always_ff @(negedge clk) begin
            if (rst)              r <= '0;
            else if (en && !hold) r <= d;
         end
         assign q = r;
         AST_RST_CLEARS: assert property (@(negedge clk) disable iff (rst)
            $past(rst) |-> q == '0);                                   // R4
         AST_HOLD_KEEPS: assert property (@(negedge clk) disable iff (rst)
            hold |=> $stable(q));                                      // R2
         AST_EN_FREEZES: assert property (@(negedge clk) disable iff (rst)
            !en |=> $stable(q));                                       // R3
         AST_LOAD_TAKES: assert property (@(negedge clk) disable iff (rst)
            (en && !hold) |=> q == $past(d));                          // R10
      end else begin : g_pos
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)              r <= '0;
            else if (en && !hold) r <= d;
         end
         assign q = r;
         AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> q == '0);                                   // R4
         AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
            hold |=> $stable(q));                                      // R2
         AST_EN_FREEZES: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(q));                                       // R3
         AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
            (en && !hold) |=> q == $past(d));                          // R1
      end
   endgenerate
endmodule

// File: rtl/msf_mul.sv
module msf_mul #(
   parameter int AW = 8,
   parameter int BW = 8,
   parameter bit AS = 1'b0,
   parameter bit BS = 1'b0
) (
   input  logic [AW-1:0]    a,
   input  logic [BW-1:0]    b,
   output logic [AW+BW-1:0] p
);
   localparam int PW = AW + BW;
   logic [PW-1:0] ax, bx;
   generate
      if (AS) begin : g_as
         assign ax = {{BW{a[AW-1]}}, a};
      end else begin : g_au
         assign ax = {{BW{1'b0}}, a};
      end
      if (BS) begin : g_bs
         assign bx = {{AW{b[BW-1]}}, b};
      end else begin : g_bu
         assign bx = {{AW{1'b0}}, b};
      end
   endgenerate
   // low PW bits of the extended product equal the mixed-sign product
   always_comb p = ax * bx;
endmodule

// File: rtl/msf_top.sv
module msf_top #(
   parameter int W          = 16,
   parameter bit A_REG      = 1'b0,
   parameter bit B_REG      = 1'b0,
   parameter bit C_REG      = 1'b0,
   parameter bit D_REG      = 1'b0,
   parameter bit HI_PREG    = 1'b0,
   parameter bit LO_PREG    = 1'b0,
   parameter bit FULL_PREG1 = 1'b0,
   parameter bit FULL_PREG2 = 1'b0,
   parameter bit A_SIGNED   = 1'b0,
   parameter bit B_SIGNED   = 1'b0,
   parameter bit FALL_EDGE  = 1'b0,
   parameter bit HALF_ONLY  = 1'b0
) (
   input  logic           clk,
   input  logic           clk_en,
   input  logic           rst_hi,
   input  logic           rst_lo,
   input  logic           hold_a,
   input  logic           hold_b,
   input  logic           hold_c,
   input  logic           hold_d,
   input  logic [W-1:0]   a_in,
   input  logic [W-1:0]   b_in,
   input  logic [W-1:0]   c_in,
   input  logic [W-1:0]   d_in,
   output logic [W-1:0]   c_out,
   output logic [W-1:0]   d_out,
   output logic [W-1:0]   prod_hi,
   output logic [W-1:0]   prod_lo,
   output logic [2*W-1:0] prod_full
);
   import msf_pkg::*;
   localparam int H  = half_of(W);
   localparam int FW = 2 * W;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("msf_top: W must be even and at least 4");
      end
   endgenerate

   logic [W-1:0]  a_q, b_q;
   logic [W-1:0]  hi_raw, lo_raw;
   logic [FW-1:0] full_raw, full_mid;

   msf_reg #(.W(W), .PRESENT(A_REG), .FALL(FALL_EDGE)) u_reg_a (
      .clk(clk), .en(clk_en), .rst(rst_hi), .hold(hold_a), .d(a_in), .q(a_q));
   msf_reg #(.W(W), .PRESENT(B_REG), .FALL(FALL_EDGE)) u_reg_b (
      .clk(clk), .en(clk_en), .rst(rst_lo), .hold(hold_b), .d(b_in), .q(b_q));
   msf_reg #(.W(W), .PRESENT(C_REG), .FALL(FALL_EDGE)) u_reg_c (
      .clk(clk), .en(clk_en), .rst(rst_hi), .hold(hold_c), .d(c_in), .q(c_out));
   msf_reg #(.W(W), .PRESENT(D_REG), .FALL(FALL_EDGE)) u_reg_d (
      .clk(clk), .en(clk_en), .rst(rst_lo), .hold(hold_d), .d(d_in), .q(d_out));

   msf_mul #(.AW(H), .BW(H), .AS(A_SIGNED), .BS(B_SIGNED)) u_mul_hi (
      .a(a_q[W-1:H]), .b(b_q[W-1:H]), .p(hi_raw));
   msf_mul #(.AW(H), .BW(H), .AS(1'b0), .BS(1'b0)) u_mul_lo (
      .a(a_q[H-1:0]), .b(b_q[H-1:0]), .p(lo_raw));

   generate
      if (HALF_ONLY) begin : g_no_full
         assign full_raw = '0;
      end else begin : g_full
         msf_mul #(.AW(W), .BW(W), .AS(A_SIGNED), .BS(B_SIGNED)) u_mul_full (
            .a(a_q), .b(b_q), .p(full_raw));
      end
   endgenerate

   msf_reg #(.W(W), .PRESENT(HI_PREG), .FALL(FALL_EDGE)) u_preg_hi (
      .clk(clk), .en(clk_en), .rst(rst_hi), .hold(1'b0), .d(hi_raw), .q(prod_hi));
   msf_reg #(.W(W), .PRESENT(LO_PREG), .FALL(FALL_EDGE)) u_preg_lo (
      .clk(clk), .en(clk_en), .rst(rst_lo), .hold(1'b0), .d(lo_raw), .q(prod_lo));
   msf_reg #(.W(FW), .PRESENT(FULL_PREG1), .FALL(FALL_EDGE)) u_preg_f1 (
      .clk(clk), .en(clk_en), .rst(rst_lo), .hold(1'b0), .d(full_raw), .q(full_mid));
   msf_reg #(.W(FW), .PRESENT(FULL_PREG2), .FALL(FALL_EDGE)) u_preg_f2 (
      .clk(clk), .en(clk_en), .rst(rst_lo), .hold(1'b0), .d(full_mid), .q(prod_full));

   generate
      if (HALF_ONLY) begin : g_half_chk
         always_comb AST_FULL_ZERO: assert (prod_full == '0);          // R9
      end
   endgenerate
endmodule

// File: tb/msf_top_tb.sv
module msf_top_tb;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic clk_en = 1'b1, rst_hi = 1'b1, rst_lo = 1'b1;
   logic hold_a = 1'b0, hold_b = 1'b0, hold_c = 1'b0, hold_d = 1'b0;
   logic [15:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
   logic [15:0] c_out, d_out, prod_hi, prod_lo;
   logic [31:0] prod_full;
   logic [15:0] c_out_f, d_out_f, prod_hi_f, prod_lo_f;
   logic [31:0] prod_full_f;

   int checks = 0, errors = 0;
   string phase = "R4 reset";
   bit running = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   // main instance: every register present, A signed, B unsigned, rising edge
   msf_top #(.W(16), .A_REG(1), .B_REG(1), .C_REG(1), .D_REG(1),
             .HI_PREG(1), .LO_PREG(1), .FULL_PREG1(1), .FULL_PREG2(1),
             .A_SIGNED(1), .B_SIGNED(0), .FALL_EDGE(0), .HALF_ONLY(0)) u_dut (
      .clk(clk), .clk_en(clk_en), .rst_hi(rst_hi), .rst_lo(rst_lo),
      .hold_a(hold_a), .hold_b(hold_b), .hold_c(hold_c), .hold_d(hold_d),
      .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
      .c_out(c_out), .d_out(d_out), .prod_hi(prod_hi), .prod_lo(prod_lo),
      .prod_full(prod_full));

   // second instance: only A registered, falling edge, half-width-only
   msf_top #(.W(16), .A_REG(1), .FALL_EDGE(1), .HALF_ONLY(1)) u_dut_fall (
      .clk(clk), .clk_en(clk_en), .rst_hi(rst_hi), .rst_lo(rst_lo),
      .hold_a(hold_a), .hold_b(hold_b), .hold_c(hold_c), .hold_d(hold_d),
      .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
      .c_out(c_out_f), .d_out(d_out_f), .prod_hi(prod_hi_f), .prod_lo(prod_lo_f),
      .prod_full(prod_full_f));

   // ---------------- reference model ----------------
   function automatic logic [15:0] ref_hi(input logic [15:0] a, input logic [15:0] b);
      int x = int'($signed(a[15:8]));
      int y = int'(b[15:8]);
      return 16'(x * y);
   endfunction
   function automatic logic [15:0] ref_lo(input logic [15:0] a, input logic [15:0] b);
      int x = int'(a[7:0]);
      int y = int'(b[7:0]);
      return 16'(x * y);
   endfunction
   function automatic logic [31:0] ref_full(input logic [15:0] a, input logic [15:0] b);
      longint x = longint'($signed(a));
      longint y = longint'(b);
      return 32'(x * y);
   endfunction

   logic [15:0] m_a = '0, m_b = '0, m_c = '0, m_d = '0, m_hi = '0, m_lo = '0;
   logic [31:0] m_f1 = '0, m_f2 = '0;
   logic [15:0] m_fa = '0;

   always @(posedge clk) begin
      m_a  <= rst_hi ? 16'h0 : (clk_en && !hold_a) ? a_in : m_a;
      m_c  <= rst_hi ? 16'h0 : (clk_en && !hold_c) ? c_in : m_c;
      m_b  <= rst_lo ? 16'h0 : (clk_en && !hold_b) ? b_in : m_b;
      m_d  <= rst_lo ? 16'h0 : (clk_en && !hold_d) ? d_in : m_d;
      m_hi <= rst_hi ? 16'h0 : clk_en ? ref_hi(m_a, m_b) : m_hi;
      m_lo <= rst_lo ? 16'h0 : clk_en ? ref_lo(m_a, m_b) : m_lo;
      m_f1 <= rst_lo ? 32'h0 : clk_en ? ref_full(m_a, m_b) : m_f1;
      m_f2 <= rst_lo ? 32'h0 : clk_en ? m_f1 : m_f2;
   end
   always @(negedge clk) begin
      m_fa <= rst_hi ? 16'h0 : (clk_en && !hold_a) ? a_in : m_fa;
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, got, exp);
      end
   endtask

   task automatic compare_all();
      check("R1 c_out", 32'(c_out), 32'(m_c));
      check("R1 d_out", 32'(d_out), 32'(m_d));
      check("R6 prod_hi", 32'(prod_hi), 32'(m_hi));
      check("R6 prod_lo", 32'(prod_lo), 32'(m_lo));
      check("R7 R8 prod_full", prod_full, m_f2);
      check("R10 falling prod_lo", 32'(prod_lo_f), 32'(ref_lo(m_fa, b_in)));
      check("R9 prod_full zero", prod_full_f, 32'h0);
      check("R11 c bypass", 32'(c_out_f), 32'(c_in));
   endtask

   // one cycle: drive 2 units after the rising edge, compare 1 unit before the next
   task automatic step(input bit rh, input bit rl, input bit en, input logic [3:0] hl,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] c, input logic [15:0] d);
      @(posedge clk);
      #2;
      rst_hi = rh; rst_lo = rl; clk_en = en;
      {hold_a, hold_b, hold_c, hold_d} = hl;
      a_in = a; b_in = b; c_in = c; d_in = d;
      #(PERIOD - 3);
      if (running) compare_all();
   endtask

   initial begin
      #(PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired after %0t", $time);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(1, 1, 1, 4'h0, 16'h1234, 16'h5678, 16'h9abc, 16'hdef0);
      step(1, 1, 1, 4'h0, 16'h1234, 16'h5678, 16'h9abc, 16'hdef0);
      running = 1'b1;
      // R4: registers cleared after reset
      step(1, 1, 0, 4'hf, 16'hffff, 16'hffff, 16'hffff, 16'hffff);
      check("R4 c_out after reset", 32'(c_out), 32'h0);
      check("R4 prod_full after reset", prod_full, 32'h0);

      phase = "R1 R6 R7 corners";
      step(0, 0, 1, 4'h0, 16'h8000, 16'hffff, 16'h0001, 16'h0002);
      step(0, 0, 1, 4'h0, 16'hffff, 16'hffff, 16'h0003, 16'h0004);
      step(0, 0, 1, 4'h0, 16'h7fff, 16'h8000, 16'h0005, 16'h0006);
      step(0, 0, 1, 4'h0, 16'h80ff, 16'h80ff, 16'h0007, 16'h0008);
      step(0, 0, 1, 4'h0, 16'h0000, 16'h0000, 16'h0009, 16'h000a);

      phase = "R1 R8 random load";
      for (int i = 0; i < 60; i++)
         step(0, 0, 1, 4'h0, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

      phase = "R2 hold";
      for (int i = 0; i < 60; i++)
         step(0, 0, 1, 4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

      phase = "R3 enable";
      for (int i = 0; i < 60; i++)
         step(0, 0, 1'($urandom), 4'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom));

      phase = "R4 R5 reset priority";
      for (int i = 0; i < 80; i++)
         step(($urandom % 5) == 0, ($urandom % 5) == 0, 1'($urandom), 4'($urandom),
              16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

      phase = "R5 reset with enable low";
      step(0, 0, 1, 4'h0, 16'hffff, 16'hffff, 16'haaaa, 16'h5555);
      step(0, 0, 1, 4'h0, 16'hffff, 16'hffff, 16'haaaa, 16'h5555);
      step(1, 0, 0, 4'hf, 16'hffff, 16'hffff, 16'haaaa, 16'h5555);
      step(0, 0, 0, 4'hf, 16'hffff, 16'hffff, 16'haaaa, 16'h5555);
      check("R5 c_out cleared despite hold and enable", 32'(c_out), 32'h0);
      check("R5 d_out kept by lower half", 32'(d_out), 32'h5555);

      phase = "R8 R10 final random";
      for (int i = 0; i < 60; i++)
         step(0, 0, 1, 4'h0, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule